// File: doc/BRIEF.md
# Region-Tagged Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 64-bit virtual address space that is split into eight equal regions of 2^61 bytes each. The three most significant address bits pick one of eight region registers. The identifier held in that register, together with the virtual page number, forms the tag that every entry is compared against. The region-number bits themselves are never stored in an entry.

Translations from many address spaces can therefore stay resident side by side. A context switch only rewrites region registers. Entries whose identifier is no longer loaded stop matching, but they are not lost, and they match again once their identifier returns.

Each entry also carries a protection key. On a hit, that key is checked against a small bank of software-loaded key registers, and a key fault is flagged when no valid register holds it. Pages are a fixed 4 KB. Entries are filled through a round-robin pointer and removed by a purge that resolves its identifier through the region registers. Lookup is purely combinational.

Top module: `region_tlb`

## Requirements
- R1: While reset is active and after it is released, all entries are invalid, all region registers read zero, all key registers are invalid and the replacement pointer is at slot 0. In this state a lookup misses with `lk_pa` zero and `lk_key_fault` low.
- R2: A region-register write (`rr_we`, index `rr_sel`, value `rr_wdata`) takes effect at the clock edge. The new identifier is used by lookups, inserts and purges from the next cycle on.
- R3: Lookup is combinational. It hits when some valid entry has identifier equal to region register `lk_va[63:61]` and page number equal to `lk_va[60:12]`. On a hit `lk_pa` is `{entry page frame, lk_va[11:0]}`, and on a miss it is zero. When several entries match, the lowest-numbered one supplies the result.
- R4: The region-number bits are not compared. Two regions whose registers hold the same identifier reach the same entries for the same page number.
- R5: An insert (`ins_valid`, `ins_vpage` = address bits 63:12, `ins_ppn`, `ins_key`) writes the slot under the replacement pointer. The tag identifier is taken from region register `ins_vpage[51:49]` as it stood before that edge, so a same-cycle register write does not affect it. The entry is visible from the next cycle.
- R6: Each insert advances the replacement pointer by one, wrapping after the last slot. The seventeenth of any seventeen consecutive inserts replaces the first.
- R7: A purge (`prg_valid`, `prg_vrn`, `prg_vpn`) invalidates, in one edge, every valid entry whose identifier equals region register `prg_vrn` and whose page number equals `prg_vpn`. An entry written by an insert in the same cycle survives.
- R8: Writing a region register invalidates no entry. Restoring an earlier identifier makes its entries hit again.
- R9: Key registers are written via `key_we`, `key_sel`, `key_wdata` and `key_wvalid`. `lk_key_fault` is high exactly when the lookup hits and no valid key register equals the hitting entry's key. It is always low on a miss.
- R10: Page-offset bits `lk_va[11:0]` do not affect hit or entry choice and pass unchanged into `lk_pa[11:0]` on a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rr_we | input | 1 | Region register write strobe |
| rr_sel | input | 3 | Region register index |
| rr_wdata | input | RID_W | Region identifier to write |
| key_we | input | 1 | Key register write strobe |
| key_sel | input | log2(NKEYS) | Key register index |
| key_wdata | input | KEY_W | Key value to write |
| key_wvalid | input | 1 | Valid bit to write with the key |
| ins_valid | input | 1 | Insert strobe |
| ins_vpage | input | VA_W-PAGE_SHIFT | Virtual address bits above the page offset |
| ins_ppn | input | PPN_W | Physical page frame for the new entry |
| ins_key | input | KEY_W | Protection key for the new entry |
| prg_valid | input | 1 | Purge strobe |
| prg_vrn | input | 3 | Region number used to fetch the purge identifier |
| prg_vpn | input | VPN_W | Virtual page number to purge |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PPN_W+PAGE_SHIFT | Translated physical address, zero on miss |
| lk_key_fault | output | 1 | Hit whose key matches no valid key register |

## Verification
The assertions assume that `rst_n` is held low across at least one rising clock edge before any strobe is raised. They also assume that the lookup address is driven stably between edges, so that the checks on the pointer and on register visibility see settled values. They do not assume unique tags: the priority rule makes duplicate entries legal. The stimulus therefore draws identifiers, page numbers and keys from small pools to force frequent matches and duplicates. All strobes are driven on the falling edge, and same-cycle insert/purge and insert/register-write collisions are issued only as directed cases.

// File: rtl/region_tlb_pkg.sv
package region_tlb_pkg;
   localparam int VRN_W    = 3;
   localparam int NREGIONS = 1 << VRN_W;
   localparam int RID_MIN  = 18;
   localparam int RID_MAX  = 24;
   typedef logic [VRN_W-1:0] vrn_t;
endpackage

// File: rtl/region_tlb_rrf.sv
module region_tlb_rrf
   import region_tlb_pkg::*;
#(
   parameter int RID_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  vrn_t             wr_sel,
   input  logic [RID_W-1:0] wr_rid,
   input  vrn_t             rd_a_sel,
   output logic [RID_W-1:0] rd_a_rid,
   input  vrn_t             rd_b_sel,
   output logic [RID_W-1:0] rd_b_rid,
   input  vrn_t             rd_c_sel,
   output logic [RID_W-1:0] rd_c_rid
);
   logic [RID_W-1:0] rid_q [NREGIONS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGIONS; r++) rid_q[r] <= '0;
      end else if (wr_en) begin
         rid_q[wr_sel] <= wr_rid;
      end
   end

   assign rd_a_rid = rid_q[rd_a_sel];
   assign rd_b_rid = rid_q[rd_b_sel];
   assign rd_c_rid = rid_q[rd_c_sel];
endmodule

// File: rtl/region_tlb_keys.sv
module region_tlb_keys #(
   parameter int KEY_W = 24,
   parameter int NKEYS = 8,
   localparam int KSEL_W = $clog2(NKEYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [KSEL_W-1:0] wr_sel,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic              wr_valid,
   input  logic [KEY_W-1:0]  probe_key,
   output logic              probe_ok
);
   logic [KEY_W-1:0] key_q [NKEYS];
   logic [NKEYS-1:0] kv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kv_q <= '0;
         for (int k = 0; k < NKEYS; k++) key_q[k] <= '0;
      end else if (wr_en) begin
         key_q[wr_sel] <= wr_key;
         kv_q[wr_sel]  <= wr_valid;
      end
   end

   always_comb begin
      probe_ok = 1'b0;
      for (int k = 0; k < NKEYS; k++)
         if (kv_q[k] && key_q[k] == probe_key) probe_ok = 1'b1;
   end
endmodule

// File: rtl/region_tlb_array.sv
module region_tlb_array #(
   parameter int RID_W   = 24,
   parameter int VPN_W   = 49,
   parameter int PPN_W   = 36,
   parameter int KEY_W   = 24,
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int TAG_W  = RID_W + VPN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  logic [IDX_W-1:0] ins_idx,
   input  logic [TAG_W-1:0] ins_tag,
   input  logic [PPN_W-1:0] ins_ppn,
   input  logic [KEY_W-1:0] ins_key,
   input  logic             prg_en,
   input  logic [TAG_W-1:0] prg_tag,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic [PPN_W-1:0] hit_ppn,
   output logic [KEY_W-1:0] hit_key
);
   logic [ENTRIES-1:0]       match;
   logic [ENTRIES*PPN_W-1:0] ppn_flat;
   logic [ENTRIES*KEY_W-1:0] key_flat;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             valid_q;
      logic [TAG_W-1:0] tag_q;
      logic [PPN_W-1:0] ppn_q;
      logic [KEY_W-1:0] key_q;
      logic             wr_here;

      assign wr_here = ins_en && (ins_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    valid_q <= 1'b0;
         else if (wr_here)                              valid_q <= 1'b1;
         else if (prg_en && valid_q && tag_q == prg_tag) valid_q <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (wr_here) begin
            tag_q <= ins_tag;
            ppn_q <= ins_ppn;
            key_q <= ins_key;
         end
      end

      assign match[e] = valid_q && (tag_q == lk_tag);
      assign ppn_flat[e*PPN_W +: PPN_W] = ppn_q;
      assign key_flat[e*KEY_W +: KEY_W] = key_q;
   end

   always_comb begin
      hit     = |match;
      hit_ppn = '0;
      hit_key = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) begin
            hit_ppn = ppn_flat[i*PPN_W +: PPN_W];
            hit_key = key_flat[i*KEY_W +: KEY_W];
         end
      end
   end
endmodule

// File: rtl/region_tlb.sv
module region_tlb
   import region_tlb_pkg::*;
#(
   parameter int VA_W       = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int RID_W      = 24,
   parameter int PPN_W      = 36,
   parameter int KEY_W      = 24,
   parameter int ENTRIES    = 16,
   parameter int NKEYS      = 8,
   localparam int VPN_W     = VA_W - VRN_W - PAGE_SHIFT,
   localparam int IDX_W     = $clog2(ENTRIES),
   localparam int KSEL_W    = $clog2(NKEYS),
   localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rr_we,
   input  logic [VRN_W-1:0]         rr_sel,
   input  logic [RID_W-1:0]         rr_wdata,
   input  logic                     key_we,
   input  logic [KSEL_W-1:0]        key_sel,
   input  logic [KEY_W-1:0]         key_wdata,
   input  logic                     key_wvalid,
   input  logic                     ins_valid,
   input  logic [VA_W-PAGE_SHIFT-1:0] ins_vpage,
   input  logic [PPN_W-1:0]         ins_ppn,
   input  logic [KEY_W-1:0]         ins_key,
   input  logic                     prg_valid,
   input  logic [VRN_W-1:0]         prg_vrn,
   input  logic [VPN_W-1:0]         prg_vpn,
   input  logic [VA_W-1:0]          lk_va,
   output logic                     lk_hit,
   output logic [PA_W-1:0]          lk_pa,
   output logic                     lk_key_fault
);
   if (RID_W < RID_MIN || RID_W > RID_MAX) begin : g_bad_rid
      $error("region_tlb: RID_W must lie in the supported identifier range");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("region_tlb: ENTRIES must be at least 2");
   end
   if (NKEYS < 2) begin : g_bad_keys
      $error("region_tlb: NKEYS must be at least 2");
   end
   if (VPN_W < 1) begin : g_bad_va
      $error("region_tlb: VA_W too small for region and page fields");
   end

   vrn_t             lk_vrn, ins_vrn;
   logic [VPN_W-1:0] lk_vpn, ins_vpn;
   logic [RID_W-1:0] lk_rid, ins_rid, prg_rid;
   logic [IDX_W-1:0] ins_ptr;
   logic [PPN_W-1:0] hit_ppn;
   logic [KEY_W-1:0] hit_key;
   logic             key_ok;

   assign lk_vrn  = lk_va[VA_W-1 -: VRN_W];
   assign lk_vpn  = lk_va[VA_W-VRN_W-1 : PAGE_SHIFT];
   assign ins_vrn = ins_vpage[VA_W-PAGE_SHIFT-1 -: VRN_W];
   assign ins_vpn = ins_vpage[VPN_W-1:0];

   region_tlb_rrf #(.RID_W(RID_W)) u_rrf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(rr_we), .wr_sel(rr_sel), .wr_rid(rr_wdata),
      .rd_a_sel(lk_vrn),  .rd_a_rid(lk_rid),
      .rd_b_sel(ins_vrn), .rd_b_rid(ins_rid),
      .rd_c_sel(prg_vrn), .rd_c_rid(prg_rid)
   );

   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_ptr_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ins_ptr <= '0;
         else if (ins_valid) ins_ptr <= ins_ptr + 1'b1;
      end
   end else begin : g_ptr_wrap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         ins_ptr <= '0;
         else if (ins_valid) ins_ptr <= (ins_ptr == IDX_W'(ENTRIES - 1)) ? '0 : ins_ptr + 1'b1;
      end
   end

   region_tlb_array #(
      .RID_W(RID_W), .VPN_W(VPN_W), .PPN_W(PPN_W),
      .KEY_W(KEY_W), .ENTRIES(ENTRIES)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .ins_en(ins_valid), .ins_idx(ins_ptr),
      .ins_tag({ins_rid, ins_vpn}), .ins_ppn(ins_ppn), .ins_key(ins_key),
      .prg_en(prg_valid), .prg_tag({prg_rid, prg_vpn}),
      .lk_tag({lk_rid, lk_vpn}),
      .hit(lk_hit), .hit_ppn(hit_ppn), .hit_key(hit_key)
   );

   region_tlb_keys #(.KEY_W(KEY_W), .NKEYS(NKEYS)) u_keys (
      .clk(clk), .rst_n(rst_n),
      .wr_en(key_we), .wr_sel(key_sel), .wr_key(key_wdata), .wr_valid(key_wvalid),
      .probe_key(hit_key), .probe_ok(key_ok)
   );

   assign lk_pa        = lk_hit ? {hit_ppn, lk_va[PAGE_SHIFT-1:0]} : '0;
   assign lk_key_fault = lk_hit && !key_ok;
endmodule

// File: rtl/region_tlb_chk.sv
module region_tlb_chk #(
   parameter int VA_W    = 64,
   parameter int RID_W   = 24,
   parameter int PA_W    = 48,
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_valid,
   input logic             rr_we,
   input logic [2:0]       rr_sel,
   input logic [RID_W-1:0] rr_wdata,
   input logic [VA_W-1:0]  lk_va,
   input logic [RID_W-1:0] lk_rid,
   input logic             lk_hit,
   input logic [PA_W-1:0]  lk_pa,
   input logic             lk_key_fault,
   input logic [IDX_W-1:0] ins_ptr
);
   always @(negedge clk) begin
      if (!rst_n) AST_RESET_NO_HIT: assert (!lk_hit && ins_ptr == '0); // R1
   end

   AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      lk_key_fault |-> lk_hit); // R9

   AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> lk_pa == '0); // R3

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ins_valid |=> ins_ptr == (($past(ins_ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ins_ptr) + 1'b1)); // R6

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ins_valid |=> $stable(ins_ptr)); // R6

   AST_RR_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      rr_we |=> (lk_va[VA_W-1 -: 3] != $past(rr_sel)) || (lk_rid == $past(rr_wdata))); // R2
endmodule

bind region_tlb region_tlb_chk #(
   .VA_W(VA_W), .RID_W(RID_W), .PA_W(PA_W), .ENTRIES(ENTRIES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid),
   .rr_we(rr_we), .rr_sel(rr_sel), .rr_wdata(rr_wdata),
   .lk_va(lk_va), .lk_rid(lk_rid), .lk_hit(lk_hit), .lk_pa(lk_pa),
   .lk_key_fault(lk_key_fault), .ins_ptr(ins_ptr)
);

// File: tb/region_tlb_test.sv
module region_tlb_test;
   localparam int CLK_PERIOD = 10;
   localparam int NENT = 16;
   localparam int NK   = 8;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        rr_we = 0;
   logic [2:0]  rr_sel = 0;
   logic [23:0] rr_wdata = 0;
   logic        key_we = 0;
   logic [2:0]  key_sel = 0;
   logic [23:0] key_wdata = 0;
   logic        key_wvalid = 0;
   logic        ins_valid = 0;
   logic [51:0] ins_vpage = 0;
   logic [35:0] ins_ppn = 0;
   logic [23:0] ins_key = 0;
   logic        prg_valid = 0;
   logic [2:0]  prg_vrn = 0;
   logic [48:0] prg_vpn = 0;
   logic [63:0] lk_va = 0;
   logic        lk_hit;
   logic [47:0] lk_pa;
   logic        lk_key_fault;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   region_tlb uut (.*);

   // bench model, built from the requirements
   logic [23:0] m_rr [8];
   logic [23:0] m_kk [NK];
   logic        m_kv [NK];
   logic        m_v  [NENT];
   logic [23:0] m_rid[NENT];
   logic [48:0] m_vpn[NENT];
   logic [35:0] m_ppn[NENT];
   logic [23:0] m_key[NENT];
   int          m_ptr;

   function automatic logic [48:0] vpn_pool(int k);
      return 49'(k * 40503 + 7);
   endfunction
   function automatic logic [23:0] rid_pool(int k);
      return 24'(k * 24'h1357 + 24'h0a5);
   endfunction
   function automatic logic [23:0] key_pool(int k);
      return 24'(k * 24'h2b1 + 24'h11);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_rr[i] = '0;
      for (int i = 0; i < NK; i++) begin m_kk[i] = '0; m_kv[i] = 1'b0; end
      for (int i = 0; i < NENT; i++) m_v[i] = 1'b0;
      m_ptr = 0;
   endtask

   task automatic cyc(input logic rw, input logic [2:0] rs, input logic [23:0] rd,
                      input logic kw, input logic [2:0] ks, input logic [23:0] kd, input logic kv,
                      input logic iv, input logic [51:0] ivp, input logic [35:0] ip, input logic [23:0] ik,
                      input logic pv, input logic [2:0] pr, input logic [48:0] pn);
      logic [23:0] old_rr [8];
      rr_we = rw; rr_sel = rs; rr_wdata = rd;
      key_we = kw; key_sel = ks; key_wdata = kd; key_wvalid = kv;
      ins_valid = iv; ins_vpage = ivp; ins_ppn = ip; ins_key = ik;
      prg_valid = pv; prg_vrn = pr; prg_vpn = pn;
      @(posedge clk);
      for (int i = 0; i < 8; i++) old_rr[i] = m_rr[i];
      if (pv)
         for (int e = 0; e < NENT; e++)
            if (m_v[e] && m_rid[e] == old_rr[pr] && m_vpn[e] == pn) m_v[e] = 1'b0;
      if (iv) begin
         m_v[m_ptr] = 1'b1; m_rid[m_ptr] = old_rr[ivp[51:49]];
         m_vpn[m_ptr] = ivp[48:0]; m_ppn[m_ptr] = ip; m_key[m_ptr] = ik;
         m_ptr = (m_ptr + 1) % NENT;
      end
      if (rw) m_rr[rs] = rd;
      if (kw) begin m_kk[ks] = kd; m_kv[ks] = kv; end
      @(negedge clk);
      rr_we = 0; key_we = 0; ins_valid = 0; prg_valid = 0;
   endtask

   task automatic wr_rr(input logic [2:0] s, input logic [23:0] d);
      cyc(1, s, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic wr_key(input logic [2:0] s, input logic [23:0] d, input logic v);
      cyc(0, 0, 0, 1, s, d, v, 0, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic ins(input logic [2:0] r, input logic [48:0] vp, input logic [35:0] p, input logic [23:0] k);
      cyc(0, 0, 0, 0, 0, 0, 0, 1, {r, vp}, p, k, 0, 0, 0);
   endtask
   task automatic prg(input logic [2:0] r, input logic [48:0] vp);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, r, vp);
   endtask

   // lookup check against the model; called between edges
   task automatic look(input logic [63:0] va, input string req);
      logic        eh = 1'b0;
      logic [47:0] epa = '0;
      logic        ef = 1'b0;
      logic        kok = 1'b0;
      lk_va = va;
      #1;
      for (int e = NENT - 1; e >= 0; e--)
         if (m_v[e] && m_rid[e] == m_rr[va[63:61]] && m_vpn[e] == va[60:12]) begin
            eh = 1'b1; epa = {m_ppn[e], va[11:0]};
            kok = 1'b0;
            for (int k = 0; k < NK; k++) if (m_kv[k] && m_kk[k] == m_key[e]) kok = 1'b1;
         end
      ef = eh && !kok;
      checks++;
      if (lk_hit !== eh || lk_pa !== epa || lk_key_fault !== ef) begin
         errors++;
         $display("FAIL %s va=%h actual hit=%b pa=%h fault=%b expected hit=%b pa=%h fault=%b",
                  req, va, lk_hit, lk_pa, lk_key_fault, eh, epa, ef);
      end
   endtask

   function automatic logic [63:0] mkva(logic [2:0] r, logic [48:0] vp, logic [11:0] off);
      return {r, vp, off};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      look(mkva(3, vpn_pool(1), 12'h123), "R1 during reset");
      rst_n = 1;
      @(negedge clk);
      look(mkva(0, 49'd0, 12'h0), "R1 after reset");

      // R2 R5 R3 R10 basic fill and lookup
      wr_rr(1, rid_pool(1));
      wr_key(0, key_pool(0), 1);
      ins(1, vpn_pool(0), 36'h0abcd1234, key_pool(0));
      look(mkva(1, vpn_pool(0), 12'hfed), "R3 R5 hit with offset R10");
      look(mkva(1, vpn_pool(0), 12'h000), "R10 offset zero");
      look(mkva(1, vpn_pool(2), 12'h000), "R3 miss other vpn");

      // R4 region bits not compared
      look(mkva(2, vpn_pool(0), 12'h010), "R4 region with other rid misses");
      wr_rr(2, rid_pool(1));
      look(mkva(2, vpn_pool(0), 12'h010), "R4 R2 alias region hits");

      // R8 switching identifiers keeps entries
      wr_rr(1, rid_pool(3));
      look(mkva(1, vpn_pool(0), 12'h020), "R8 swapped out misses");
      wr_rr(1, rid_pool(1));
      look(mkva(1, vpn_pool(0), 12'h020), "R8 restored hits");

      // R9 key checking
      ins(1, vpn_pool(5), 36'h111, key_pool(2));
      look(mkva(1, vpn_pool(5), 12'h0), "R9 fault without key");
      wr_key(3, key_pool(2), 1);
      look(mkva(1, vpn_pool(5), 12'h0), "R9 key loaded no fault");
      wr_key(3, key_pool(2), 0);
      look(mkva(1, vpn_pool(5), 12'h0), "R9 invalid key faults");

      // R7 purge via aliasing region
      prg(2, vpn_pool(0));
      look(mkva(1, vpn_pool(0), 12'h0), "R7 purged");
      look(mkva(1, vpn_pool(5), 12'h0), "R7 other entry kept");

      // R6 round robin: 17 inserts, the first is replaced
      wr_rr(4, rid_pool(2));
      for (int i = 0; i < 17; i++) ins(4, 49'(1000 + i), 36'(i + 500), key_pool(0));
      look(mkva(4, 49'd1000, 12'h0), "R6 oldest replaced");
      look(mkva(4, 49'd1001, 12'h0), "R6 second kept");
      look(mkva(4, 49'd1016, 12'h0), "R6 newest present");

      // R7 same-cycle insert and purge of the same tag
      cyc(0, 0, 0, 0, 0, 0, 0, 1, {3'd4, 49'd1001}, 36'h777, key_pool(0), 1, 3'd4, 49'd1001);
      look(mkva(4, 49'd1001, 12'h0), "R7 inserted survives same-cycle purge");

      // R5 same-cycle region write and insert uses old identifier
      cyc(1, 3'd5, rid_pool(3), 0, 0, 0, 0, 1, {3'd5, 49'd2000}, 36'h999, key_pool(0), 0, 0, 0);
      look(mkva(5, 49'd2000, 12'h0), "R5 new rid misses");
      wr_rr(6, 24'd0);
      look(mkva(6, 49'd2000, 12'h0), "R5 old rid hits");

      // constrained random mix, R3 R4 R6 R7 R8 R9 R2
      for (int n = 0; n < 1500; n++) begin
         int op = $urandom_range(0, 9);
         logic [2:0] r = 3'($urandom_range(0, 7));
         logic [48:0] vp = vpn_pool($urandom_range(0, 7));
         case (op)
            0: wr_rr(r, rid_pool($urandom_range(0, 3)));
            1: wr_key(3'($urandom_range(0, 7)), key_pool($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            2, 3, 4: ins(r, vp, 36'($urandom), key_pool($urandom_range(0, 3)));
            5: prg(r, vp);
            default: ;
         endcase
         look(mkva(3'($urandom_range(0, 7)), vpn_pool($urandom_range(0, 7)), 12'($urandom)),
              "R3 R4 R7 R8 R9 random");
         @(negedge clk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule